// File: doc/BRIEF.md
# Per-Line Object Selection Engine

This block picks the moving objects that appear on one display line. A 256-byte object table holds 64 entries of four bytes each. Byte 0 of an entry is its vertical position, byte 1 its tile number, byte 2 its attribute and byte 3 its horizontal position. A processor fills the table through a byte pointer register and a data port.

Before each line the renderer pulses a clear strobe, which fills a 32-byte line table with 0xFF. It then pulses a start strobe together with the line number and an object-height select. The engine checks one entry per clock, in ascending index order. Each entry whose vertical span covers the line is copied into the next free slot of the line table, up to eight slots.

A ninth covering entry sets a sticky overflow flag and ends the scan at once. A done pulse marks the end of every scan, and the found count stays readable beside it. The renderer reads the line table through a plain random-access read port. A separate strobe clears the overflow flag at the start of the pre-render line.

Top module: `obj_line_scan`

## Requirements
- R1: After reset the found count is 0, the overflow flag is 0, done is 0 and the byte pointer is 0, so a data-port write with no prior pointer write lands at byte 0.
- R2: A pointer write loads the byte pointer. A data-port write stores the byte at the pointer and then increments it, wrapping from 255 to 0. The data-port read value is the byte at the pointer, and reading it does not move the pointer. A pointer write in the same cycle as a data write wins.
- R3: An entry is selected when line >= Y and line < Y + H, where Y is byte 0 of the entry and H is 16 when the height select is 1 and 8 otherwise. The sum is formed in 9 bits, so entries near Y = 255 do not wrap to low lines.
- R4: Selected entries are copied in ascending index order into slots 0 to 7. Slot k occupies line-table bytes 4k to 4k+3, holding Y, tile, attribute and X in that order. The found count equals the number of slots filled.
- R5: When a ninth entry is selected, the overflow flag is set and the scan stops. The count stays at 8 and slots 0 to 7 are unchanged.
- R6: The engine examines one entry per clock. With the start strobe sampled at clock edge 0, done is high for exactly one cycle after edge 64 when there is no overflow, or after edge n+1 when entry n is the ninth selected entry.
- R7: A clear strobe sets all 32 line-table bytes to 0xFF on the next edge, so slots that a scan leaves unfilled read 0xFF.
- R8: The overflow flag stays set across later scans until the pre-render strobe clears it.
- R9: A start strobe that arrives while a scan is running is ignored, and the running scan completes with its original line and height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_ptr_we | input | 1 | Load the byte pointer |
| cpu_ptr_wdata | input | 8 | New byte pointer value |
| cpu_data_we | input | 1 | Store a byte at the pointer, then increment the pointer |
| cpu_data_wdata | input | 8 | Byte to store |
| cpu_data_rdata | output | 8 | Byte of the object table at the pointer |
| line_start | input | 1 | Start-of-scan strobe |
| line_num | input | 8 | Line to select objects for, sampled with line_start |
| tall_sel | input | 1 | 1: objects are 16 lines tall; 0: 8 lines |
| sec_clear | input | 1 | Fill the line table with 0xFF |
| prerender | input | 1 | Clear the overflow flag |
| sec_raddr | input | 5 | Line-table byte address |
| sec_rdata | output | 8 | Line-table byte at sec_raddr |
| hit_count | output | 4 | Number of slots filled by the last scan |
| overflow | output | 1 | Sticky: more than eight entries were selected |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Three table layouts are swept over every line number with both heights. In the first, Y grows by 4 per entry, which yields two or four hits spread through the table and shows index ordering and the exact upper bound of each span. In the second, positions sit near 250, so the 9-bit sum is separated from an 8-bit wrapping one at low lines. In the third, many entries share Y values around 100, which forces overflow at varying entry indexes and shows the early stop, the done timing and the frozen slots. Separate runs cover a start strobe that arrives mid-scan, the stickiness of overflow across scans, clearing the line table on its own, and pointer wrap and write priority on the processor side.

// File: rtl/obj_scan_pkg.sv
package obj_scan_pkg;
  localparam int BYTES_PER_OBJ = 4;
  localparam int BYTE_W        = 8;

  typedef enum logic {SC_IDLE, SC_SCAN} scan_state_e;

  // One object table entry; byte 0 (vertical position) in the low bits.
  typedef struct packed {
    logic [BYTE_W-1:0] xpos;
    logic [BYTE_W-1:0] attr;
    logic [BYTE_W-1:0] tile;
    logic [BYTE_W-1:0] ypos;
  } obj_entry_t;
endpackage

// File: rtl/obj_cpu_port.sv
module obj_cpu_port #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             data_we,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (ptr_we)       ptr_d = ptr_wdata;
    else if (data_we) ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R2: a data write alone advances the pointer by one, wrapping
  a_r2_post_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R2: a pointer write wins and loads the value given
  a_r2_pointer_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr == $past(ptr_wdata)));
endmodule

// File: rtl/obj_primary_ram.sv
module obj_primary_ram
  import obj_scan_pkg::*;
#(
  parameter int N_OBJ = 64,
  parameter int PTR_W = 8,
  parameter int IDX_W = 6
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [PTR_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]         rd_data,
  input  logic [IDX_W-1:0]          obj_idx,
  output obj_entry_t                obj_out
);
  localparam int DEPTH = N_OBJ * BYTES_PER_OBJ;

  logic [BYTE_W-1:0] mem [DEPTH];

  // Storage array: no reset, contents defined by processor writes.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // Whole-entry read port for the scan: four bytes of one entry at once.
  generate
    for (genvar b = 0; b < BYTES_PER_OBJ; b++) begin : g_entry_byte
      assign obj_out[BYTE_W*b +: BYTE_W] = mem[{obj_idx, 2'(b)}];
    end
  endgenerate
endmodule

// File: rtl/obj_scan_ctrl.sv
module obj_scan_ctrl
  import obj_scan_pkg::*;
#(
  parameter int N_OBJ  = 64,
  parameter int SLOTS  = 8,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] line,
  input  logic              tall,
  input  logic              prerender,
  input  obj_entry_t        obj,
  output logic [IDX_W-1:0]  obj_idx,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              done
);
  localparam int SUM_W = BYTE_W + 1;

  scan_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] line_q, line_d;
  logic              tall_q, tall_d;
  logic              ovf_q, ovf_d;
  logic              done_q, done_d;

  logic [SUM_W-1:0]  y_ext, l_ext, span, y_lim;
  logic              hit, full, last;

  // Span test in 9 bits so that Y + height never wraps.
  assign y_ext = {1'b0, obj.ypos};
  assign l_ext = {1'b0, line_q};
  assign span  = tall_q ? SUM_W'(16) : SUM_W'(8);
  assign y_lim = y_ext + span;
  assign hit   = (l_ext >= y_ext) && (l_ext < y_lim);
  assign full  = (cnt_q == CNT_W'(SLOTS));
  assign last  = (idx_q == IDX_W'(N_OBJ - 1));

  assign wr_en   = (state_q == SC_SCAN) && hit && !full;
  assign wr_slot = cnt_q[SLOT_W-1:0];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    tall_d  = tall_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    if (prerender) ovf_d = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        if (start) begin
          state_d = SC_SCAN;
          idx_d   = '0;
          cnt_d   = '0;
          line_d  = line;
          tall_d  = tall;
        end
      end
      SC_SCAN: begin
        if (hit && full) begin
          ovf_d   = 1'b1;
          done_d  = 1'b1;
          state_d = SC_IDLE;
        end else begin
          if (hit) cnt_d = cnt_q + 1'b1;
          if (last) begin
            done_d  = 1'b1;
            state_d = SC_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      line_q  <= '0;
      tall_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
      tall_q  <= tall_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  assign obj_idx  = idx_q;
  assign count    = cnt_q;
  assign overflow = ovf_q;
  assign done     = done_q;

  // R5: the count never passes the number of slots
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(SLOTS));

  // R5: overflow only rises together with the end of a scan
  a_r5_overflow_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> done);

  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: the count grows by at most one per clock
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_SCAN) |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  // R8: the pre-render strobe clears overflow unless a new overflow ends a scan
  a_r8_prerender_clear: assert property (@(posedge clk) disable iff (!rst_n)
    prerender |=> (!overflow || done));

  // R9: a start during a scan leaves the captured line alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_SCAN && start) |=> (line_q == $past(line_q)));
endmodule

// File: rtl/obj_sec_buf.sv
module obj_sec_buf
  import obj_scan_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int SLOT_W  = 3,
  parameter int RADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  obj_entry_t         wr_obj,
  input  logic [RADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0]  rdata
);
  localparam int NBYTES = SLOTS * BYTES_PER_OBJ;

  logic [BYTE_W-1:0] buf_q [NBYTES];
  logic [BYTE_W-1:0] buf_d [NBYTES];

  always_comb begin
    buf_d = buf_q;
    if (clear) begin
      for (int i = 0; i < NBYTES; i++) buf_d[i] = '1;
    end else if (wr_en) begin
      for (int b = 0; b < BYTES_PER_OBJ; b++)
        buf_d[{wr_slot, 2'(b)}] = wr_obj[BYTE_W*b +: BYTE_W];
    end
  end

  // Line table storage: defined by the clear strobe, not by reset.
  always_ff @(posedge clk) begin
    buf_q <= buf_d;
  end

  assign rdata = buf_q[raddr];

  // R7: a clear leaves the first and last bytes at all ones
  a_r7_clear_fill: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (buf_q[0] == '1) && (buf_q[NBYTES-1] == '1));

  // R4: a slot that is not written and not cleared keeps its bytes
  a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !wr_en) |=> $stable(buf_q[0]));
endmodule

// File: rtl/obj_line_scan.sv
module obj_line_scan
  import obj_scan_pkg::*;
#(
  parameter int N_OBJ = 64,
  parameter int SLOTS = 8,
  localparam int PTR_W   = $clog2(N_OBJ * BYTES_PER_OBJ),
  localparam int IDX_W   = $clog2(N_OBJ),
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int RADDR_W = $clog2(SLOTS * BYTES_PER_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_ptr_we,
  input  logic [PTR_W-1:0]   cpu_ptr_wdata,
  input  logic               cpu_data_we,
  input  logic [7:0]         cpu_data_wdata,
  output logic [7:0]         cpu_data_rdata,
  input  logic               line_start,
  input  logic [7:0]         line_num,
  input  logic               tall_sel,
  input  logic               sec_clear,
  input  logic               prerender,
  input  logic [RADDR_W-1:0] sec_raddr,
  output logic [7:0]         sec_rdata,
  output logic [CNT_W-1:0]   hit_count,
  output logic               overflow,
  output logic               done
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PTR_W-1:0]  ptr;
  logic [IDX_W-1:0]  obj_idx;
  obj_entry_t        obj;
  logic              sec_we;
  logic [SLOT_W-1:0] sec_slot;

  obj_cpu_port #(.PTR_W(PTR_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ptr_we    (cpu_ptr_we),
    .ptr_wdata (cpu_ptr_wdata),
    .data_we   (cpu_data_we),
    .ptr       (ptr)
  );

  obj_primary_ram #(.N_OBJ(N_OBJ), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .wr_en   (cpu_data_we),
    .wr_addr (ptr),
    .wr_data (cpu_data_wdata),
    .rd_addr (ptr),
    .rd_data (cpu_data_rdata),
    .obj_idx (obj_idx),
    .obj_out (obj)
  );

  obj_scan_ctrl #(
    .N_OBJ(N_OBJ), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (line_start),
    .line      (line_num),
    .tall      (tall_sel),
    .prerender (prerender),
    .obj       (obj),
    .obj_idx   (obj_idx),
    .wr_en     (sec_we),
    .wr_slot   (sec_slot),
    .count     (hit_count),
    .overflow  (overflow),
    .done      (done)
  );

  obj_sec_buf #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .RADDR_W(RADDR_W)) u_sec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (sec_clear),
    .wr_en   (sec_we),
    .wr_slot (sec_slot),
    .wr_obj  (obj),
    .raddr   (sec_raddr),
    .rdata   (sec_rdata)
  );
endmodule

// File: tb/tb_obj_line_scan.sv
module tb_obj_line_scan;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_ptr_we, cpu_data_we, line_start, tall_sel, sec_clear, prerender;
  logic [7:0] cpu_ptr_wdata, cpu_data_wdata, cpu_data_rdata, line_num, sec_rdata;
  logic [4:0] sec_raddr;
  logic [3:0] hit_count;
  logic       overflow, done;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [256];
  bit model_ovf = 1'b0;

  always #5 clk = ~clk;

  obj_line_scan dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_ptr_we(cpu_ptr_we), .cpu_ptr_wdata(cpu_ptr_wdata),
    .cpu_data_we(cpu_data_we), .cpu_data_wdata(cpu_data_wdata),
    .cpu_data_rdata(cpu_data_rdata),
    .line_start(line_start), .line_num(line_num), .tall_sel(tall_sel),
    .sec_clear(sec_clear), .prerender(prerender),
    .sec_raddr(sec_raddr), .sec_rdata(sec_rdata),
    .hit_count(hit_count), .overflow(overflow), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  function automatic logic [7:0] ybyte(input int kind, input int i);
    case (kind)
      0:       return 8'(i * 4);
      1:       return 8'(100 + (i % 4));
      default: return 8'(250 + (i % 6));
    endcase
  endfunction

  task automatic set_ptr(input logic [7:0] v);
    @(negedge clk); cpu_ptr_we = 1'b1; cpu_ptr_wdata = v;
    @(negedge clk); cpu_ptr_we = 1'b0;
  endtask

  task automatic load_table(input int kind);
    set_ptr(8'd0);
    for (int i = 0; i < 64; i++) begin
      model[4*i]   = ybyte(kind, i);
      model[4*i+1] = 8'(i);
      model[4*i+2] = 8'(i) ^ 8'h5A;
      model[4*i+3] = 8'(255 - 3 * i);
    end
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); cpu_data_we = 1'b1; cpu_data_wdata = model[a];
    end
    @(negedge clk); cpu_data_we = 1'b0;
  endtask

  task automatic run_scan(input int line, input bit tall, input bit pre,
                          input int inj_at, input int inj_line);
    logic [7:0] exp_buf [32];
    int cnt = 0, stop = 63, n = 0, h;
    bit ovf = 1'b0;
    h = tall ? 16 : 8;
    for (int k = 0; k < 32; k++) exp_buf[k] = 8'hFF;
    for (int i = 0; i < 64; i++) begin
      int y = model[4*i];
      if (line >= y && line < y + h) begin
        if (cnt < 8) begin
          for (int b = 0; b < 4; b++) exp_buf[4*cnt+b] = model[4*i+b];
          cnt++;
        end else begin
          ovf = 1'b1; stop = i; break;
        end
      end
    end
    if (pre) model_ovf = 1'b0;
    if (ovf) model_ovf = 1'b1;
    @(negedge clk); sec_clear = 1'b1; prerender = pre;
    @(negedge clk); sec_clear = 1'b0; prerender = 1'b0;
    line_num = 8'(line); tall_sel = tall; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    while (!done && n < 100) begin
      if (n == inj_at) begin line_start = 1'b1; line_num = 8'(inj_line); tall_sel = ~tall; end
      else line_start = 1'b0;
      @(negedge clk); n++;
    end
    line_start = 1'b0;
    chk("R6 done cycle", n, stop + 1);
    chk("R3 hit count", hit_count, cnt);
    chk("R5 overflow", overflow, model_ovf);
    for (int k = 0; k < 32; k++) begin
      sec_raddr = 5'(k); #1;
      chk(exp_buf[k] == 8'hFF && k >= 4 * cnt ? "R7 unfilled slot" : "R4 slot byte",
          sec_rdata, exp_buf[k]);
    end
    @(negedge clk);
    chk("R6 done one cycle", done, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cpu_ptr_we = 0; cpu_data_we = 0; line_start = 0; tall_sel = 0;
    sec_clear = 0; prerender = 0; cpu_ptr_wdata = 0; cpu_data_wdata = 0;
    line_num = 0; sec_raddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 count", hit_count, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 done", done, 0);
    @(negedge clk); cpu_data_we = 1'b1; cpu_data_wdata = 8'hA5;
    @(negedge clk); cpu_data_we = 1'b0;
    set_ptr(8'd0);
    chk("R1 pointer at zero", cpu_data_rdata, 8'hA5);

    // R2 processor port
    load_table(0);
    chk("R2 wrap to byte 0", cpu_data_rdata, model[0]);
    @(negedge clk);
    chk("R2 read keeps pointer", cpu_data_rdata, model[0]);
    set_ptr(8'd77);
    chk("R2 pointer load", cpu_data_rdata, model[77]);
    @(negedge clk); cpu_data_we = 1'b1; cpu_data_wdata = model[77];
    @(negedge clk); cpu_data_we = 1'b0;
    chk("R2 post increment", cpu_data_rdata, model[78]);
    @(negedge clk); cpu_data_we = 1'b1; cpu_ptr_we = 1'b1; cpu_ptr_wdata = 8'd9;
    cpu_data_wdata = model[78];
    @(negedge clk); cpu_data_we = 1'b0; cpu_ptr_we = 1'b0;
    chk("R2 pointer write wins", cpu_data_rdata, model[9]);

    // R3 R4 R6 spread layout, every line, both heights
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 256; l++) run_scan(l, t[0], 1'b1, -1, 0);

    // R9 start mid-scan ignored
    run_scan(20, 1'b0, 1'b1, 5, 200);
    run_scan(36, 1'b1, 1'b1, 40, 3);

    // R7 clear alone
    run_scan(8, 1'b1, 1'b1, -1, 0);
    @(negedge clk); sec_clear = 1'b1;
    @(negedge clk); sec_clear = 1'b0;
    for (int k = 0; k < 32; k++) begin
      sec_raddr = 5'(k); #1;
      chk("R7 clear fill", sec_rdata, 8'hFF);
    end

    // R3 no-wrap layout near the bottom
    load_table(2);
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 256; l++) run_scan(l, t[0], 1'b1, -1, 0);

    // R5 crowded layout
    load_table(1);
    for (int t = 0; t < 2; t++)
      for (int l = 90; l < 124; l++) run_scan(l, t[0], 1'b1, -1, 0);

    // R8 sticky overflow
    run_scan(101, 1'b0, 1'b1, -1, 0);
    chk("R8 overflow set", overflow, 1'b1);
    run_scan(10, 1'b0, 1'b0, -1, 0);
    chk("R8 overflow kept", overflow, 1'b1);
    @(negedge clk); prerender = 1'b1;
    @(negedge clk); prerender = 1'b0;
    chk("R8 overflow cleared", overflow, 1'b0);

    summary();
    $finish;
  end
endmodule